// File: doc/BRIEF.md
# Stateful CRC-32 Accumulator

This block is a register-slave CRC-32 engine. It holds one running checksum that carries over from one bus write to the next. Software first starts a reset through the control register, and the accumulator is loaded with all ones. Software then polls the control register until the busy bit drops. After that it writes 32-bit or 16-bit words into the data register. Each accepted write folds its word into the checksum in the same clock. The engine uses the generator 0x04C11DB7.

Input bits can be mirrored before they enter the engine. There are two ways to do this: within each byte, or across the whole written unit (16 or 32 bits). The value read back can also be bit-mirrored. With unit mirroring and output mirroring both enabled, the block gives the reflected CRC-32 used by USB and Ethernet. In that setting every byte is taken least significant bit first, and the bytes of a word are taken lowest first.

A data read returns the raw accumulator and changes no state. Software applies the final inversion (XOR with 0xFFFFFFFF) itself. There is one shared state with no contexts, so callers must serialize their access.

Top module: `crc32_acc_periph`

## Requirements
- R1: With control field in_mode=2'b10 (bits 3:2) and out_refl=1 (bit 1), a 32-bit data write gives a read value equal to the byte-wise reflected CRC-32 update. That update uses the constant 0xEDB88320 and takes bytes 0,1,2,3 of the word in that order, each least significant bit first.
- R2: After the block reset, and after any control write with bit 0 set, the data register reads 0xFFFFFFFF.
- R3: A 16-bit data write (bus_half=1) folds in only bus_wdata[15:0], low byte first. Bits 31:16 have no effect.
- R4: Writes of 16 and 32 bits in any mix update one shared accumulator in sequence.
- R5: After a control write with bit 0 set, control bit 0 reads 1 for exactly RST_CYCLES cycles and then reads 0.
- R6: A data write accepted while control bit 0 reads 1 is ignored.
- R7: A read of either register leaves the accumulator unchanged. The data read returns the raw accumulator without the final inversion.
- R8: With in_mode=2'b00 and out_refl=0, each write is folded most significant bit first and is read back unmirrored.
- R9: With in_mode=2'b01, the bits within each byte are mirrored before the write is folded most significant bit first.
- R10: out_refl=1 bit-reverses the 32-bit value read from the data register.
- R11: The control register resets to 0. It reads back as {in_mode, out_refl, busy} in bits 3:0, and all upper bits are 0.
- R12: A data read in the cycle after a data write returns the updated accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_half | input | 1 | Data write width: 1 selects 16 bits, 0 selects 32 bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read of the selected register |

## Verification
The bench builds the block with RST_CYCLES=3. This makes the busy window last several read cycles, so the bench can count how long control bit 0 stays set. It also lets a data write land inside the window and be shown to have no effect. The polynomial and bit order are fixed, so the bench covers all four input and output mirroring settings. It runs a mixed-width vector sequence against two reference models written separately: a reflected byte-wise model and a forward bit-serial model.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
    localparam int CRC_W  = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int NBYTES = CRC_W / BYTE_W;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        IN_ASIS      = 2'b00,
        IN_PER_BYTE  = 2'b01,
        IN_PER_UNIT  = 2'b10,
        IN_PER_UNIT2 = 2'b11
    } in_mode_e;

    typedef struct packed {
        in_mode_e in_mode;
        logic     out_refl;
    } ctrl_cfg_t;

    localparam int CFG_W = $bits(ctrl_cfg_t);

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] rev_half(input logic [HALF_W-1:0] v);
        logic [HALF_W-1:0] r;
        for (int i = 0; i < HALF_W; i++) r[i] = v[HALF_W-1-i];
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] rev_word(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

    // Folds the low nbits of d into c, highest of those bits first.
    function automatic logic [CRC_W-1:0] fold_bits(input logic [CRC_W-1:0] c,
                                                   input logic [CRC_W-1:0] d,
                                                   input int nbits);
        logic [CRC_W-1:0] s;
        logic fb;
        s = c;
        for (int i = CRC_W-1; i >= 0; i--) begin
            if (i < nbits) begin
                fb = s[CRC_W-1] ^ d[i];
                s  = {s[CRC_W-2:0], 1'b0};
                if (fb) s = s ^ CRC_POLY;
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/crc32_ctrl_regs.sv
module crc32_ctrl_regs
    import crc32_pkg::*;
#(
    parameter int RST_CYCLES = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_ctrl,
    input  logic [CFG_W:0]         wfield,
    output ctrl_cfg_t              cfg,
    output logic                   busy,
    output logic                   go,
    output logic [CRC_W-1:0]       ctrl_rdata
);
    localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign go = wr_ctrl && wfield[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            if (wr_ctrl) cfg <= ctrl_cfg_t'(wfield[CFG_W:1]);
            if (go) begin
                busy <= 1'b1;
                cnt  <= CNT_LOAD;
            end else if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end
        end
    end

    assign ctrl_rdata = {{(CRC_W-CFG_W-1){1'b0}}, cfg, busy};

    p_go_sets_busy_r5: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);
    p_busy_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0 && !go) |=> !busy);
    p_idle_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go) |=> !busy);
endmodule

// File: rtl/crc32_in_shaper.sv
module crc32_in_shaper
    import crc32_pkg::*;
(
    input  in_mode_e           in_mode,
    input  logic               half,
    input  logic [CRC_W-1:0]   din,
    output logic [CRC_W-1:0]   shaped
);
    logic [CRC_W-1:0] masked;
    logic [CRC_W-1:0] per_byte;

    assign masked = half ? {{(CRC_W-HALF_W){1'b0}}, din[HALF_W-1:0]} : din;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign per_byte[b*BYTE_W +: BYTE_W] = rev_byte(masked[b*BYTE_W +: BYTE_W]);
    end

    always_comb begin
        unique case (in_mode)
            IN_ASIS:     shaped = masked;
            IN_PER_BYTE: shaped = per_byte;
            default:     shaped = half ? {{(CRC_W-HALF_W){1'b0}}, rev_half(masked[HALF_W-1:0])}
                                       : rev_word(masked);
        endcase
    end

    always_comb begin
        if (half) a_half_upper_zero_r3: assert (shaped[CRC_W-1:HALF_W] == '0);
    end
endmodule

// File: rtl/crc32_fold.sv
module crc32_fold
    import crc32_pkg::*;
(
    input  logic [CRC_W-1:0] acc,
    input  logic [CRC_W-1:0] shaped,
    input  logic             half,
    output logic [CRC_W-1:0] nxt
);
    logic [CRC_W-1:0] nxt_half;
    logic [CRC_W-1:0] nxt_word;

    assign nxt_half = fold_bits(acc, shaped, HALF_W);
    assign nxt_word = fold_bits(acc, shaped, CRC_W);
    assign nxt      = half ? nxt_half : nxt_word;
endmodule

// File: rtl/crc32_acc_periph.sv
module crc32_acc_periph
    import crc32_pkg::*;
#(
    parameter int RST_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_half,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    ctrl_cfg_t        cfg;
    logic             busy;
    logic             go;
    logic [CRC_W-1:0] ctrl_rdata;
    logic [CRC_W-1:0] shaped;
    logic [CRC_W-1:0] acc;
    logic [CRC_W-1:0] acc_nxt;
    logic             wr_ctrl;
    logic             wr_data;

    assign wr_ctrl = bus_wr && (reg_sel_e'(bus_sel) == SEL_CTRL);
    assign wr_data = bus_wr && (reg_sel_e'(bus_sel) == SEL_DATA);

    crc32_ctrl_regs #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wfield     (bus_wdata[CFG_W:0]),
        .cfg        (cfg),
        .busy       (busy),
        .go         (go),
        .ctrl_rdata (ctrl_rdata)
    );

    crc32_in_shaper u_shape (
        .in_mode (cfg.in_mode),
        .half    (bus_half),
        .din     (bus_wdata),
        .shaped  (shaped)
    );

    crc32_fold u_fold (
        .acc    (acc),
        .shaped (shaped),
        .half   (bus_half),
        .nxt    (acc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)                    acc <= CRC_INIT;
        else if (go)                acc <= CRC_INIT;
        else if (wr_data && !busy)  acc <= acc_nxt;
    end

    always_comb begin
        if (reg_sel_e'(bus_sel) == SEL_DATA)
            bus_rdata = cfg.out_refl ? rev_word(acc) : acc;
        else
            bus_rdata = ctrl_rdata;
    end

    p_go_loads_init_r2: assert property (@(posedge clk) disable iff (rst)
        go |=> (acc == CRC_INIT));
    p_busy_blocks_data_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy) |=> $stable(acc));
    p_no_write_holds_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(acc));
    p_ctrl_reset_zero_r11: assert property (@(posedge clk)
        rst |=> (ctrl_rdata == '0));
endmodule

// File: tb/tb_crc32_acc_periph.sv
module tb_crc32_acc_periph;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 3;
    localparam int NVEC       = 8;
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 32'h34333231}, {1'b0, 32'h38373635}, {1'b1, 32'hABCD0039},
        {1'b1, 32'h0000FFFF}, {1'b0, 32'h00000000}, {1'b0, 32'hFFFFFFFF},
        {1'b1, 32'h5A5A1234}, {1'b0, 32'hDEADBEEF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc32_acc_periph #(.RST_CYCLES(RST_CYC)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] m_refl(input logic [31:0] c, input logic [31:0] d, input int nbytes);
        logic [31:0] s = c;
        for (int b = 0; b < nbytes; b++) begin
            s ^= {24'h0, d[b*8 +: 8]};
            for (int k = 0; k < 8; k++) s = s[0] ? ((s >> 1) ^ 32'hEDB88320) : (s >> 1);
        end
        return s;
    endfunction

    function automatic logic [31:0] m_fwd(input logic [31:0] c, input logic [31:0] d, input int nbits);
        logic [31:0] s = c;
        for (int i = nbits-1; i >= 0; i--) begin
            if (s[31] ^ d[i]) s = (s << 1) ^ 32'h04C11DB7;
            else              s = s << 1;
        end
        return s;
    endfunction

    function automatic logic [31:0] brev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] bytes_rev(input logic [31:0] v);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++) r[b*8+i] = v[b*8+7-i];
        return r;
    endfunction

    task automatic wr(input logic sel, input logic half, input logic [31:0] d);
        @(negedge clk);
        bus_sel = sel; bus_half = half; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic start(input logic [3:0] cfg);
        wr(1'b0, 1'b0, {28'h0, cfg});
        repeat (RST_CYC + 1) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, v2, m;
        int ones;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        rd(1'b0, v); chk("R11 ctrl reset", v, 32'h0);
        rd(1'b1, v); chk("R2 data after reset", v, 32'hFFFFFFFF);

        // R5: busy bit duration
        wr(1'b0, 1'b0, 32'h0000000B);
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            rd(1'b0, v);
            if (v[0]) ones++; else break;
        end
        chk("R5 busy cycles", ones, RST_CYC);
        chk("R11 ctrl readback", v, 32'h0000000A);

        // R6: write during busy ignored
        wr(1'b0, 1'b0, 32'h0000000B);
        wr(1'b1, 1'b0, 32'h12345678);
        repeat (RST_CYC + 1) @(negedge clk);
        rd(1'b1, v); chk("R6 write while busy", v, 32'hFFFFFFFF);

        // R1/R4/R12 vector walk in reflected setting
        m = 32'hFFFFFFFF;
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b1, VEC[i][32], VEC[i][31:0]);
            m = m_refl(m, VEC[i][31:0], VEC[i][32] ? 2 : 4);
            rd(1'b1, v);
            chk(VEC[i][32] ? "R3 R4 R12 half vec" : "R1 R4 R12 word vec", v, m);
        end

        // R7: reads have no side effect
        rd(1'b0, v2);
        rd(1'b1, v);  rd(1'b1, v2);
        chk("R7 repeat read", v2, m);
        chk("R7 final inversion", v2 ^ 32'hFFFFFFFF, m ^ 32'hFFFFFFFF);

        // R3: upper bits of a half write ignored
        start(4'hB);
        wr(1'b1, 1'b1, 32'hFFFF00A5);
        rd(1'b1, v); chk("R3 upper ignored", v, m_refl(32'hFFFFFFFF, 32'h000000A5, 2));

        // R2: restart reloads all ones
        wr(1'b0, 1'b0, 32'h0000000B);
        repeat (RST_CYC + 1) @(negedge clk);
        rd(1'b1, v); chk("R2 restart", v, 32'hFFFFFFFF);

        // R8: forward, unmirrored
        start(4'h1);
        m = 32'hFFFFFFFF;
        wr(1'b1, 1'b0, 32'hCAFEF00D); m = m_fwd(m, 32'hCAFEF00D, 32);
        wr(1'b1, 1'b1, 32'h77771234); m = m_fwd(m, 32'h00001234, 16);
        rd(1'b1, v); chk("R8 forward", v, m);

        // R9: per-byte mirroring
        start(4'h5);
        m = 32'hFFFFFFFF;
        wr(1'b1, 1'b0, 32'h01020304); m = m_fwd(m, bytes_rev(32'h01020304), 32);
        wr(1'b1, 1'b1, 32'h0000C3E1); m = m_fwd(m, bytes_rev(32'h0000C3E1), 16);
        rd(1'b1, v); chk("R9 per byte", v, m);

        // R10: output mirroring only
        start(4'h3);
        wr(1'b1, 1'b0, 32'h89ABCDEF);
        rd(1'b1, v); chk("R10 out mirror", v, brev(m_fwd(32'hFFFFFFFF, 32'h89ABCDEF, 32)));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule